// File: doc/BRIEF.md
# Two-Stage Configuration Latch Controller

This block owns the working configuration of a supervisory chip. Every configuration byte is held in two stages: a front stage that receives writes and downloads, and a back stage whose outputs drive the functions of the chip. The two stages let software prepare a new configuration without disturbing the one in use, and then switch all of it in a single cycle.

After reset the block waits for the supply to clear its undervoltage lockout. It then reads every stored byte from a nonvolatile memory, one byte per cycle, into the front stage. When the last byte has landed, it copies the whole front stage into the back stage in one clock edge and reports the configuration as ready. A fixed number of cycles later, it issues a single request for the sequencer to fetch its first state. Until the configuration is ready, every bus access is refused.

Once the block is running, a control register selects how writes are applied. In transparent mode a write reaches both stages at once. In staged mode a write reaches only the front stage, and a commit strobe copies every front stage to the back stage together. A reload command refetches the stored image, discarding any edits. A page-erase command passes through to the memory only if an enable bit in the same control register is set.

Top module: `cfg_latch_ctrl`

## Requirements
- R1: After reset, and until `uvlo_ok` is seen high, `busy`, `cfg_done`, `nvm_rd` and `se_load` are 0 and `cfg_q` is all zeros.
- R2: Once `uvlo_ok` is high, the block reads nonvolatile addresses 0 to NREG-1 in ascending order, one per cycle, with `busy` high. The byte at address i comes from `nvm_data` one cycle after its read and becomes configuration byte i.
- R3: `cfg_q` holds its value while the download is in progress. All NREG bytes then change in the same cycle in which `cfg_done` rises, and `cfg_done` stays high from then on.
- R4: While the block is not ready (before the first download completes, or while a reload runs), `bus_nack` is high in any cycle with `wr_en` or `erase_cmd`. Such a write has no effect on any register.
- R5: A write to CTRL_ADDR sets the mode from bit 0. If bit 0 is 1 (transparent), a write of value v to a configuration address a < NREG shows on byte a of `cfg_q` on the next cycle.
- R6: If control bit 0 is 0 (staged), a configuration write leaves `cfg_q` unchanged. Reading the same address through `rd_addr`/`rd_data` returns the new value.
- R7: A write to CTRL_ADDR with bit 1 set copies every front-stage byte to `cfg_q` on the next cycle. Bit 1 always reads back as 0, while bits 0 and 2 read back as last written.
- R8: A write to RELOAD_ADDR with bit 0 set reruns the nonvolatile download and the all-at-once copy, with `busy` high throughout. Afterwards `cfg_q` equals the stored image. The reload register reads back as 0.
- R9: `erase_go` follows `erase_cmd` only when the block is ready and control bit 2 is 1. Otherwise an erase command is ignored.
- R10: `se_load` pulses high for exactly one cycle, SE_DLY cycles after `cfg_done` rises. It pulses only once after reset, and a reload does not repeat it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uvlo_ok | input | 1 | Supply has cleared undervoltage lockout |
| wr_en | input | 1 | Register write strobe from the bus slave |
| wr_addr | input | 8 | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | DW | Read data (front stage, control, reload) |
| bus_nack | output | 1 | Access refused because the block is not ready |
| erase_cmd | input | 1 | Page erase command from the bus slave |
| erase_go | output | 1 | Erase command passed on to the memory |
| nvm_rd | output | 1 | Nonvolatile read strobe |
| nvm_addr | output | NAW | Nonvolatile read address |
| nvm_data | input | DW | Nonvolatile read data, one cycle after the strobe |
| busy | output | 1 | Download or reload in progress |
| cfg_done | output | 1 | First configuration download complete |
| se_load | output | 1 | One-cycle request for the first sequencer state load |
| cfg_q | output | NREG*DW | Back-stage configuration bytes, byte i at bits [i*DW +: DW] |

## Verification
If a front-stage byte is wrong, it shows up on `rd_data` at once. It reaches `cfg_q` only at the next commit, reload completion or transparent write, so a staged error can stay hidden for as long as software delays the commit. If the download counter slips, a byte lands in the wrong position, which becomes visible on `cfg_q` in the cycle `cfg_done` rises, together with a broken ascending `nvm_addr` sequence in the cycles before. If the mode or enable bits are wrong, this appears on the very next configuration write or erase command, and a wrong sequencer-delay count moves `se_load` by the size of the error.

// File: rtl/cfg_latch_ctrl.sv
`timescale 1ns/1ps
module cfg_latch_ctrl #(
  parameter int NREG = 16,
  parameter int DW = 8,
  parameter int SE_DLY = 125000,
  parameter logic [7:0] CTRL_ADDR = 8'hF0,
  parameter logic [7:0] RELOAD_ADDR = 8'hF1,
  parameter int NAW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                uvlo_ok,
  input  logic                wr_en,
  input  logic [7:0]          wr_addr,
  input  logic [DW-1:0]       wr_data,
  input  logic [7:0]          rd_addr,
  output logic [DW-1:0]       rd_data,
  output logic                bus_nack,
  input  logic                erase_cmd,
  output logic                erase_go,
  output logic                nvm_rd,
  output logic [NAW-1:0]      nvm_addr,
  input  logic [DW-1:0]       nvm_data,
  output logic                busy,
  output logic                cfg_done,
  output logic                se_load,
  output logic [NREG*DW-1:0]  cfg_q
);
  localparam int CW = $clog2(NREG + 1);
  localparam int SW = $clog2(SE_DLY + 1);

  typedef enum logic [1:0] {S_OFF, S_LOAD, S_COMMIT, S_RUN} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic             xp, ers_en, done_q, se_arm, se_p;
  logic [SW-1:0]    se_cnt;
  logic [NREG*DW-1:0] a_flat;
  logic [DW-1:0]    rd_cfg;

  wire ready  = (st == S_RUN);
  wire wr_ok  = wr_en & ready;
  wire cap    = (st == S_LOAD) && (cnt != '0);
  wire [CW-1:0] cap_idx = cnt - CW'(1);
  wire commit = wr_ok && (wr_addr == CTRL_ADDR) && wr_data[1];
  wire reload = wr_ok && (wr_addr == RELOAD_ADDR) && wr_data[0];
  wire copy_all = (st == S_COMMIT) || commit;

  assign busy     = (st == S_LOAD) || (st == S_COMMIT);
  assign bus_nack = (wr_en | erase_cmd) & ~ready;
  assign erase_go = erase_cmd & ready & ers_en;
  assign nvm_rd   = (st == S_LOAD) && (cnt < CW'(NREG));
  assign nvm_addr = cnt[NAW-1:0];
  assign cfg_done = done_q;
  assign se_load  = se_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_OFF;
      cnt <= '0;
      xp <= 1'b0;
      ers_en <= 1'b0;
      done_q <= 1'b0;
      se_arm <= 1'b0;
      se_cnt <= '0;
      se_p <= 1'b0;
    end else begin
      se_p <= 1'b0;
      case (st)
        S_OFF: if (uvlo_ok) begin
          st <= S_LOAD;
          cnt <= '0;
        end
        S_LOAD: begin
          if (cnt == CW'(NREG)) st <= S_COMMIT;
          else cnt <= cnt + CW'(1);
        end
        S_COMMIT: begin
          st <= S_RUN;
          if (!done_q) begin
            done_q <= 1'b1;
            se_arm <= 1'b1;
            se_cnt <= '0;
          end
        end
        default: begin
          if (reload) begin
            st <= S_LOAD;
            cnt <= '0;
          end
          if (wr_ok && wr_addr == CTRL_ADDR) begin
            xp <= wr_data[0];
            ers_en <= wr_data[2];
          end
        end
      endcase
      if (se_arm) begin
        if (se_cnt == SW'(SE_DLY - 1)) begin
          se_p <= 1'b1;
          se_arm <= 1'b0;
        end else begin
          se_cnt <= se_cnt + SW'(1);
        end
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] a_r, b_r;
    wire hit = wr_ok && (wr_addr == 8'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_r <= '0;
        b_r <= '0;
      end else begin
        if (cap && cap_idx == CW'(g)) a_r <= nvm_data;
        else if (hit) a_r <= wr_data;
        if (copy_all) b_r <= a_r;
        else if (hit && xp) b_r <= wr_data;
      end
    end
    assign a_flat[g*DW +: DW] = a_r;
    assign cfg_q[g*DW +: DW]  = b_r;
  end

  always_comb begin
    rd_cfg = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_addr == 8'(i)) rd_cfg = a_flat[i*DW +: DW];
  end

  always_comb begin
    if (rd_addr == CTRL_ADDR) rd_data = {{(DW-3){1'b0}}, ers_en, 1'b0, xp};
    else if (rd_addr == RELOAD_ADDR) rd_data = '0;
    else rd_data = rd_cfg;
  end
endmodule

// File: rtl/cfg_latch_ctrl_chk.sv
`timescale 1ns/1ps
module cfg_latch_ctrl_chk #(
  parameter int NREG = 16,
  parameter int DW = 8,
  parameter int NAW = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               bus_nack,
  input logic               erase_go,
  input logic               nvm_rd,
  input logic [NAW-1:0]     nvm_addr,
  input logic               busy,
  input logic               cfg_done,
  input logic               se_load,
  input logic [NREG*DW-1:0] cfg_q
);
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(cfg_q)); // R3
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> cfg_done); // R3
  AST_NVM_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    nvm_rd && $past(nvm_rd) |-> nvm_addr == $past(nvm_addr) + NAW'(1)); // R2
  AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !nvm_rd); // R2
  AST_SE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    se_load |=> !se_load); // R10
  AST_SE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    se_load |-> cfg_done); // R10
  AST_ERASE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |-> cfg_done && !busy && !bus_nack); // R9
  AST_NACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_en |-> bus_nack); // R4
endmodule

bind cfg_latch_ctrl cfg_latch_ctrl_chk #(.NREG(NREG), .DW(DW), .NAW(NAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .bus_nack(bus_nack),
  .erase_go(erase_go), .nvm_rd(nvm_rd), .nvm_addr(nvm_addr), .busy(busy),
  .cfg_done(cfg_done), .se_load(se_load), .cfg_q(cfg_q)
);

// File: tb/test_cfg_latch_ctrl.sv
`timescale 1ns/1ps
module test_cfg_latch_ctrl;
  localparam int NREG = 8;
  localparam int DW = 8;
  localparam int SE_DLY = 40;
  localparam int NAW = 3;
  localparam logic [7:0] CA = 8'hF0;
  localparam logic [7:0] RA = 8'hF1;

  logic clk = 0, rst_n = 0, uvlo_ok = 0, wr_en = 0, erase_cmd = 0;
  logic [7:0] wr_addr = 0, rd_addr = 0;
  logic [DW-1:0] wr_data = 0, rd_data, nvm_data;
  logic bus_nack, erase_go, nvm_rd, busy, cfg_done, se_load;
  logic [NAW-1:0] nvm_addr;
  logic [NREG*DW-1:0] cfg_q;

  int checks = 0, fails = 0, seed = 0;
  int cyc = 0, done_cyc = -1, se_cyc = -1, se_cnt = 0;
  int exp_addr = 0, addr_bad = 0, q_changes = 0, partial = 0;
  logic [NREG*DW-1:0] prev_q = '0;

  always #2 clk = ~clk;

  cfg_latch_ctrl #(.NREG(NREG), .DW(DW), .SE_DLY(SE_DLY), .CTRL_ADDR(CA),
    .RELOAD_ADDR(RA), .NAW(NAW)) i_cfg_latch_ctrl (
    .clk(clk), .rst_n(rst_n), .uvlo_ok(uvlo_ok), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .bus_nack(bus_nack),
    .erase_cmd(erase_cmd), .erase_go(erase_go), .nvm_rd(nvm_rd), .nvm_addr(nvm_addr),
    .nvm_data(nvm_data), .busy(busy), .cfg_done(cfg_done), .se_load(se_load), .cfg_q(cfg_q));

  function automatic logic [7:0] img(int i, int s);
    return 8'(i * 29 + s * 71 + 3);
  endfunction

  function automatic logic [NREG*DW-1:0] image(int s);
    logic [NREG*DW-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*DW +: DW] = img(i, s);
    return v;
  endfunction

  always_ff @(posedge clk) if (nvm_rd) nvm_data <= img(int'(nvm_addr), seed);

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (nvm_rd) begin
      if (int'(nvm_addr) != exp_addr) addr_bad <= addr_bad + 1;
      exp_addr <= exp_addr + 1;
    end
    if (cfg_done && done_cyc < 0) done_cyc <= cyc;
    if (se_load) begin se_cnt <= se_cnt + 1; se_cyc <= cyc; end
    if (cfg_q != prev_q && busy) begin
      q_changes <= q_changes + 1;
      if (cfg_q != image(seed)) partial <= partial + 1;
    end
    if (cfg_q != prev_q && !busy && done_cyc < 0) begin
      q_changes <= q_changes + 1;
      if (cfg_q != image(seed)) partial <= partial + 1;
    end
    prev_q <= cfg_q;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  function automatic logic [7:0] qb(int i);
    return cfg_q[i*DW +: DW];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [NREG*DW-1:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(!busy && !cfg_done && !nvm_rd && !se_load, "R1 idle outputs", {busy, cfg_done, nvm_rd, se_load}, 0);
    chk(cfg_q == '0, "R1 cfg_q zero", cfg_q, 0);
    wr_en = 1; wr_addr = 8'h00; wr_data = 8'hAA; #0.5;
    chk(bus_nack == 1, "R4 nack before download", bus_nack, 1);
    @(negedge clk); wr_en = 0;

    uvlo_ok = 1;
    @(negedge clk); @(negedge clk);
    chk(busy == 1, "R2 busy during download", busy, 1);
    wr_en = 1; wr_addr = 8'h01; wr_data = 8'h55; #0.5;
    chk(bus_nack == 1, "R4 nack during download", bus_nack, 1);
    @(negedge clk); wr_en = 0;
    for (int t = 0; t < 50 && !cfg_done; t++) @(negedge clk);
    @(negedge clk);
    chk(cfg_q == image(0), "R3 image after download", cfg_q, image(0));
    chk(addr_bad == 0 && exp_addr == NREG, "R2 address sequence", exp_addr, NREG);
    chk(q_changes == 1 && partial == 0, "R3 single-cycle copy", partial, 0);
    rd_addr = 8'h01; #0.5;
    chk(rd_data == img(1, 0), "R4 refused write ignored", rd_data, img(1, 0));

    repeat (SE_DLY + 5) @(negedge clk);
    chk(se_cyc - done_cyc == SE_DLY, "R10 sequencer delay", se_cyc - done_cyc, SE_DLY);
    chk(se_cnt == 1, "R10 single pulse", se_cnt, 1);

    wr(CA, 8'h01);
    rd_addr = CA; #0.5;
    chk(rd_data == 8'h01, "R5 ctrl readback", rd_data, 1);
    for (int i = 0; i < NREG; i++) begin
      wr(8'(i), 8'(i * 13 + 100));
      chk(qb(i) == 8'(i * 13 + 100), "R5 transparent write", qb(i), 8'(i * 13 + 100));
    end

    wr(CA, 8'h00);
    snap = cfg_q;
    for (int i = 0; i < NREG; i++) begin
      wr(8'(i), 8'(i * 7 + 200));
      rd_addr = 8'(i); #0.5;
      chk(cfg_q == snap, "R6 staged keeps outputs", cfg_q, snap);
      chk(rd_data == 8'(i * 7 + 200), "R6 staged front value", rd_data, 8'(i * 7 + 200));
    end
    wr(CA, 8'h02);
    for (int i = 0; i < NREG; i++)
      chk(qb(i) == 8'(i * 7 + 200), "R7 commit copies all", qb(i), 8'(i * 7 + 200));
    rd_addr = CA; #0.5;
    chk(rd_data == 8'h00, "R7 commit bit reads 0", rd_data, 0);
    wr(CA, 8'h07);
    rd_addr = CA; #0.5;
    chk(rd_data == 8'h05, "R7 ctrl bits 0 and 2 kept", rd_data, 5);

    wr(CA, 8'h00);
    @(negedge clk); erase_cmd = 1; #0.5;
    chk(erase_go == 0, "R9 erase blocked", erase_go, 0);
    @(negedge clk); erase_cmd = 0;
    wr(CA, 8'h04);
    @(negedge clk); erase_cmd = 1; #0.5;
    chk(erase_go == 1 && bus_nack == 0, "R9 erase enabled", erase_go, 1);
    @(negedge clk); erase_cmd = 0;

    seed = 1; exp_addr = 0;
    wr(RA, 8'h01);
    chk(busy == 1, "R8 busy during reload", busy, 1);
    wr_en = 1; wr_addr = 8'h02; wr_data = 8'h11; erase_cmd = 1; #0.5;
    chk(bus_nack == 1 && erase_go == 0, "R4 nack during reload", bus_nack, 1);
    @(negedge clk); wr_en = 0; erase_cmd = 0;
    for (int t = 0; t < 50 && busy; t++) @(negedge clk);
    chk(cfg_q == image(1), "R8 reload restores image", cfg_q, image(1));
    chk(exp_addr == NREG && addr_bad == 0, "R8 reload reads all", exp_addr, NREG);
    rd_addr = RA; #0.5;
    chk(rd_data == 8'h00, "R8 reload reg reads 0", rd_data, 0);
    repeat (SE_DLY + 5) @(negedge clk);
    chk(se_cnt == 1, "R10 no pulse after reload", se_cnt, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule